// File: doc/BRIEF.md
# IRA LDPC Parity Accumulator Encoder

This block produces the parity part of a codeword for an irregular repeat-accumulate LDPC code. Information bits enter one per cycle through a valid/ready handshake. Each bit comes with the base parity addresses of its group. The block keeps a running offset. The offset grows by a fixed step for each bit of a group and returns to zero at the start of the next group. For each bit, the block adds this offset to each base address that the bit uses, reduces the sum modulo the parity length, and XORs the bit into those parity positions. The parity positions are held in an internal bit store.

After the last information bit is accepted, the block walks once through the store in ascending order. At each position it XORs in the bit below it. This turns the store into a running (prefix) XOR. The block then streams the parity bits out one per cycle, each with its index, and ends the frame with a one-cycle done pulse.

The parity length, the offset step, the group size, the number of information bits and the largest number of base addresses per bit are all parameters. A frame begins with a start pulse, which clears the store.

Top module: `ira_parity_encoder`

## Requirements
- R1: During reset and after it, `in_ready`, `out_valid` and `done` are 0 until a start pulse arrives.
- R2: A start pulse clears every parity bit and raises `in_ready` in the next cycle. This holds even when it arrives while a frame is partly loaded.
- R3: For the information bit at position m in the frame, with base address x (0 <= x < N_PAR), the touched parity index is (x + Q_STEP·(m mod GROUP)) mod N_PAR, and that parity bit is XORed with the information bit.
- R4: The offset restarts at 0 on the first bit of every group of GROUP consecutive bits, so all bits of a group share their base addresses.
- R5: Only the first `in_deg` base slots are used. Slot d occupies `in_base[d*AW +: AW]`, where AW = clog2(N_PAR). Slots at and above `in_deg` are ignored.
- R6: When two used slots of one bit map to the same parity index, the two XORs cancel.
- R7: After the last of K_INFO bits is accepted, an accumulation pass runs for N_PAR-1 cycles. It applies p[j] ^= p[j-1] for j = 1 up to N_PAR-1, in that order. The streamed bits are therefore the prefix XOR of the store.
- R8: `in_ready` is 0 during the accumulation and output phases, and `in_valid` has no effect there.
- R9: Parity bits stream out in index order 0 to N_PAR-1, one per cycle with no gaps. `out_idx` carries the index, and the store does not change while streaming.
- R10: `done` is high for exactly one cycle, the cycle after the one that carries index N_PAR-1, and `out_valid` is low in that cycle.
- R11: A cycle with `in_ready` high and `in_valid` low consumes no bit and does not advance the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears the store and begins a frame |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block accepts an information bit |
| in_bit | input | 1 | Information bit value |
| in_deg | input | clog2(DEG_MAX+1) | Number of base slots used by this bit |
| in_base | input | DEG_MAX·clog2(N_PAR) | Packed base addresses, slot d at bits d·AW upward |
| out_valid | output | 1 | A parity bit is on `out_bit` |
| out_bit | output | 1 | Parity bit value |
| out_idx | output | clog2(N_PAR) | Index of the parity bit on `out_bit` |
| done | output | 1 | One-cycle pulse after the last parity bit |

## Verification
Each frame is checked against the address rule and the prefix XOR, both computed in the bench. A single set bit with a sum that wraps past N_PAR shows the modulo reduction and the group offset. A frame of all ones at full degree loads every slot at once. Frames with a mixed degree, with unused slots filled with live-looking addresses, and with duplicate slots separate the slot masking from the XOR cancellation. Frames with gaps in `in_valid`, with `in_valid` held high while the block is busy, and with a restart in the middle of a frame show that neither stalls nor busy-phase inputs change the result, and that start truly clears the store.

// File: rtl/ira_parity_encoder.sv
module ira_parity_encoder #(
  parameter int N_PAR   = 12,
  parameter int Q_STEP  = 3,
  parameter int GROUP   = 4,
  parameter int K_INFO  = 8,
  parameter int DEG_MAX = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic                                  in_bit,
  input  logic [$clog2(DEG_MAX+1)-1:0]          in_deg,
  input  logic [DEG_MAX*$clog2(N_PAR)-1:0]      in_base,
  output logic                                  out_valid,
  output logic                                  out_bit,
  output logic [$clog2(N_PAR)-1:0]              out_idx,
  output logic                                  done
);
  localparam int AW = $clog2(N_PAR);
  localparam int DW = $clog2(DEG_MAX+1);
  localparam int MW = (K_INFO > 1) ? $clog2(K_INFO) : 1;
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [AW:0] N_EXT = (AW+1)'(N_PAR);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ACC, S_OUT} state_t;

  state_t            state;
  logic [N_PAR-1:0]  par_q, par_d;
  logic [MW-1:0]     m_q;
  logic [GW-1:0]     grp_q;
  logic [AW-1:0]     off_q, off_nx;
  logic [AW-1:0]     pos_q;
  logic [AW-1:0]     idx_w [DEG_MAX];
  logic              take;
  logic [AW:0]       off_sum;

  assign in_ready  = (state == S_LOAD);
  assign out_valid = (state == S_OUT);
  assign out_idx   = pos_q;
  assign out_bit   = par_q[pos_q];
  assign take      = in_ready && in_valid;

  for (genvar d = 0; d < DEG_MAX; d++) begin : g_idx
    logic [AW:0] sum;
    assign sum      = {1'b0, in_base[d*AW +: AW]} + {1'b0, off_q};
    assign idx_w[d] = (sum >= N_EXT) ? AW'(sum - N_EXT) : sum[AW-1:0];
  end

  always_comb begin
    par_d = par_q;
    for (int d = 0; d < DEG_MAX; d++)
      if (DW'(d) < in_deg) par_d[idx_w[d]] = par_d[idx_w[d]] ^ in_bit;
  end

  assign off_sum = {1'b0, off_q} + (AW+1)'(Q_STEP);
  assign off_nx  = (off_sum >= N_EXT) ? AW'(off_sum - N_EXT) : off_sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      par_q <= '0;
      m_q   <= '0;
      grp_q <= '0;
      off_q <= '0;
      pos_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= S_LOAD;
        par_q <= '0;
        m_q   <= '0;
        grp_q <= '0;
        off_q <= '0;
        pos_q <= '0;
      end else begin
        case (state)
          S_LOAD: if (take) begin
            par_q <= par_d;
            if (grp_q == GW'(GROUP-1)) begin
              grp_q <= '0;
              off_q <= '0;
            end else begin
              grp_q <= grp_q + 1'b1;
              off_q <= off_nx;
            end
            if (m_q == MW'(K_INFO-1)) begin
              state <= (N_PAR > 1) ? S_ACC : S_OUT;
              pos_q <= (N_PAR > 1) ? AW'(1) : '0;
            end else begin
              m_q <= m_q + 1'b1;
            end
          end
          S_ACC: begin
            par_q[pos_q] <= par_q[pos_q] ^ par_q[pos_q - AW'(1)];
            if (pos_q == AW'(N_PAR-1)) begin
              state <= S_OUT;
              pos_q <= '0;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          S_OUT: begin
            if (pos_q == AW'(N_PAR-1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_offset_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < AW'(N_PAR));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (par_q == '0) && in_ready);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !start |=> !out_valid || (out_idx == $past(out_idx) + 1'b1));

  assert_store_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !start |=> $stable(par_q));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid) && ($past(out_idx) == AW'(N_PAR-1)) && !out_valid);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !in_ready && !out_valid && !done);
endmodule

// File: tb/ira_parity_encoder_tb.sv
module ira_parity_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_PAR = 12, Q_STEP = 3, GROUP = 4, K_INFO = 8, DEG_MAX = 3;
  localparam int AW = $clog2(N_PAR);
  localparam int DW = $clog2(DEG_MAX+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [DW-1:0] in_deg = '0;
  logic [DEG_MAX*AW-1:0] in_base = '0;
  logic in_ready, out_valid, out_bit, done;
  logic [AW-1:0] out_idx;

  int total = 0, bad = 0;
  int tb_bit [K_INFO];
  int tb_deg [K_INFO];
  int tb_gap [K_INFO];
  int tb_base [K_INFO][DEG_MAX];
  int expv [N_PAR];

  always #(CLK_PERIOD/2) clk = ~clk;

  ira_parity_encoder #(.N_PAR(N_PAR), .Q_STEP(Q_STEP), .GROUP(GROUP),
                       .K_INFO(K_INFO), .DEG_MAX(DEG_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_deg(in_deg), .in_base(in_base), .out_valid(out_valid),
    .out_bit(out_bit), .out_idx(out_idx), .done(done));

  task automatic chk(string rq, int act, int exp_v, string what);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp_v);
    end
  endtask

  task automatic clear_frame();
    for (int m = 0; m < K_INFO; m++) begin
      tb_bit[m] = 0; tb_deg[m] = 1; tb_gap[m] = 0;
      for (int d = 0; d < DEG_MAX; d++) tb_base[m][d] = (m / GROUP * 5 + d * 7 + 1) % N_PAR;
    end
  endtask

  task automatic model();
    for (int j = 0; j < N_PAR; j++) expv[j] = 0;
    for (int m = 0; m < K_INFO; m++)
      for (int d = 0; d < tb_deg[m]; d++) begin
        int j = (tb_base[m][d] + Q_STEP * (m % GROUP)) % N_PAR;
        expv[j] ^= tb_bit[m];
      end
    for (int j = 1; j < N_PAR; j++) expv[j] ^= expv[j-1];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", in_ready, 1, "in_ready after start");
  endtask

  task automatic feed(int cnt);
    for (int m = 0; m < cnt; m++) begin
      for (int g = 0; g < tb_gap[m]; g++) begin
        in_valid = 1'b0; in_bit = 1'b1; in_deg = DW'(DEG_MAX);
        @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_bit   = tb_bit[m][0];
      in_deg   = DW'(tb_deg[m]);
      for (int d = 0; d < DEG_MAX; d++) in_base[d*AW +: AW] = AW'(tb_base[m][d]);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(string rq, bit poke);
    int cnt = 0;
    int errs = 0;
    model();
    if (poke) begin in_valid = 1'b1; in_bit = 1'b1; in_deg = DW'(DEG_MAX); end
    chk("R8", in_ready, 0, "in_ready in accumulation");
    while (!out_valid && cnt < 4 * N_PAR) begin @(negedge clk); cnt++; end
    chk("R7", cnt, N_PAR - 1, "accumulation cycles");
    for (int i = 0; i < N_PAR; i++) begin
      if (in_ready) errs++;
      chk("R9", {31'b0, out_valid}, 1, "out_valid streaming");
      chk("R9", int'(out_idx), i, "out_idx order");
      chk(rq, {31'b0, out_bit}, expv[i], $sformatf("parity bit %0d", i));
      chk("R10", done, 0, "done early");
      @(negedge clk);
    end
    chk("R8", errs, 0, "in_ready high while streaming");
    chk("R10", done, 1, "done after last bit");
    chk("R10", out_valid, 0, "out_valid with done");
    @(negedge clk);
    chk("R10", done, 0, "done one cycle");
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", in_ready, 0, "in_ready in reset");
    chk("R1", out_valid, 0, "out_valid in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", in_ready, 0, "in_ready idle");
    chk("R1", done, 0, "done idle");
  endtask

  task automatic test_single_wrap();
    clear_frame();
    tb_bit[6] = 1; tb_deg[6] = 2;
    for (int m = 4; m < 8; m++) begin tb_base[m][0] = 5; tb_base[m][1] = 9; end
    pulse_start(); feed(K_INFO); collect("R3", 1'b0);
  endtask

  task automatic test_all_ones();
    clear_frame();
    for (int m = 0; m < K_INFO; m++) begin tb_bit[m] = 1; tb_deg[m] = DEG_MAX; end
    pulse_start(); feed(K_INFO); collect("R4", 1'b0);
  endtask

  task automatic test_deg_mask();
    clear_frame();
    for (int m = 0; m < K_INFO; m++) begin tb_bit[m] = (m % 3 != 1); tb_deg[m] = 1 + (m % DEG_MAX); end
    pulse_start(); feed(K_INFO); collect("R5", 1'b0);
  endtask

  task automatic test_collide();
    clear_frame();
    for (int m = 0; m < K_INFO; m++) begin
      tb_bit[m] = 1; tb_deg[m] = 2;
      tb_base[m][1] = tb_base[m][0];
    end
    tb_deg[3] = 3;
    pulse_start(); feed(K_INFO); collect("R6", 1'b0);
  endtask

  task automatic test_stall_busy();
    clear_frame();
    for (int m = 0; m < K_INFO; m++) begin tb_bit[m] = (m % 2); tb_deg[m] = DEG_MAX; tb_gap[m] = m % 3; end
    pulse_start(); feed(K_INFO); collect("R11", 1'b1);
  endtask

  task automatic test_restart();
    clear_frame();
    for (int m = 0; m < K_INFO; m++) begin tb_bit[m] = 1; tb_deg[m] = DEG_MAX; end
    pulse_start(); feed(3);
    clear_frame();
    pulse_start(); feed(K_INFO); collect("R2", 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_single_wrap();
    test_all_ones();
    test_deg_mask();
    test_collide();
    test_stall_busy();
    test_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule